// File: doc/BRIEF.md
# Calendar Timekeeper with Nine-Bit Day Count

This block keeps elapsed time as seconds, minutes, hours and a nine-bit day number. A prescaler divides the system clock by `TICK_DIV` to make a one-second step. Each step moves the seconds field forward and ripples carries upward. A halt control freezes both the time fields and the prescaler. A sticky flag records that the day count has rolled past its top value.

Software reads five byte-wide views of the time: seconds, minutes, hours, the day number's low byte, and a control byte. The control byte holds day bit 8 in bit 0, halt in bit 6 and the rollover flag in bit 7. Writes go through a single strobe, select and data port. The write port has no ready signal: every strobe is taken in the cycle it is raised, so there is never back-pressure.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset every output reads 0x00 and the prescaler is empty, so the first step arrives on the `TICK_DIV`-th rising edge after reset is released.
- R2: While not halted, seconds advance by exactly one every `TICK_DIV` clock cycles.
- R3: Seconds roll from 59 to 0 and carry one into minutes; minutes roll from 59 to 0 and carry one into hours.
- R4: Hours roll from 23 to 0 and carry one into the day number.
- R5: The day number is 9 bits wide. The low byte is on `out_day_lo` and bit 8 is bit 0 of `out_day_hi`, so a carry from day 255 gives `out_day_lo`=0x00 and `out_day_hi` bit 0 = 1.
- R6: A day step from 511 to 0 sets `out_day_hi` bit 7. The bit then stays set through later steps until a control-byte write (select 4) puts a 0 in data bit 7.
- R7: While `out_day_hi` bit 6 (halt) is 1, no time field changes except by a write, and the prescaler keeps its count. After the halt is released, the next step comes once the rest of the interrupted second has elapsed.
- R8: A seconds write clears the prescaler and suppresses any step in that cycle, so the next step comes exactly `TICK_DIV` cycles after the write edge.
- R9: A field holding a value above its normal range (seconds or minutes above 59, hours above 23) counts up to its bit-width maximum (63, 63 or 31), then wraps to 0 and carries nothing.
- R10: With `wr_en` high, the data is written to the field chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 day low byte, 4 control byte. It is visible on the next cycle. Data is cut to the field's width: 6 bits for seconds and minutes, 5 bits for hours, and bits 0, 6 and 7 of the control byte. Unused output bits read 0. Select codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken in the same cycle |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write data |
| out_sec | output | 8 | Seconds, zero-extended |
| out_min | output | 8 | Minutes, zero-extended |
| out_hour | output | 8 | Hours, zero-extended |
| out_day_lo | output | 8 | Day number bits 7..0 |
| out_day_hi | output | 8 | Bit 0 day bit 8, bit 6 halt, bit 7 rollover flag |

## Verification
The assertions check these rules on every cycle:
- seconds only hold or step by one outside the roll points;
- minutes and the day number stay put unless the field below them is at its carry value;
- the halt freezes all time fields;
- the rollover flag never drops without a control write;
- a minutes write lands on the next cycle.

Only the directed scenarios can show the exact step spacing after reset, after a seconds write and across a halt. They also cover the carry chain from 23:59:59 into day 256 and past day 511, the non-carrying wrap of out-of-range values, and the masking and ignoring of writes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 9;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;

  localparam int CTL_DAY8  = 0;
  localparam int CTL_HALT  = 6;
  localparam int CTL_ROLL  = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DAYLO = 3'd3,
    SEL_CTL   = 3'd4
  } rtc_sel_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_DIV = 4194304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = !hold_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (!hold_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_wrap_field.sv
module rtc_wrap_field #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] AT_LAST = W'(LAST);

  logic [W-1:0] val_q;
  logic         at_last;

  assign at_last = (val_q == AT_LAST);
  // A carry leaves only on the normal roll point; an out-of-range value
  // wraps through the natural width overflow and carries nothing.
  assign carry_o = inc_i && at_last;
  assign val_o   = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     val_q <= '0;
    else if (wr_i)  val_q <= wdata_i;
    else if (inc_i) val_q <= at_last ? '0 : val_q + 1'b1;
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 4194304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] out_sec,
  output logic [BYTE_W-1:0] out_min,
  output logic [BYTE_W-1:0] out_hour,
  output logic [BYTE_W-1:0] out_day_lo,
  output logic [BYTE_W-1:0] out_day_hi
);
  logic wr_s, wr_m, wr_h, wr_dl, wr_dh;
  logic tick, step;
  logic sec_cy, min_cy, hour_cy;
  logic [SEC_W-1:0]  sec_v;
  logic [MIN_W-1:0]  min_v;
  logic [HOUR_W-1:0] hour_v;
  logic [DAY_W-1:0]  day_q, day_nx;
  logic              halt_q, halt_nx;
  logic              roll_q, roll_nx;
  logic              day_wrap;

  assign wr_s  = wr_en && (wr_sel == SEL_SEC);
  assign wr_m  = wr_en && (wr_sel == SEL_MIN);
  assign wr_h  = wr_en && (wr_sel == SEL_HOUR);
  assign wr_dl = wr_en && (wr_sel == SEL_DAYLO);
  assign wr_dh = wr_en && (wr_sel == SEL_CTL);

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .hold_i(halt_q), .clear_i(wr_s), .tick_o(tick)
  );

  // A seconds write restarts the second, so it also drops a coincident step.
  assign step = tick && !wr_s;

  rtc_wrap_field #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc_i(step), .wr_i(wr_s),
    .wdata_i(wr_data[SEC_W-1:0]), .val_o(sec_v), .carry_o(sec_cy)
  );

  rtc_wrap_field #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
    .clk(clk), .rst_n(rst_n), .inc_i(sec_cy), .wr_i(wr_m),
    .wdata_i(wr_data[MIN_W-1:0]), .val_o(min_v), .carry_o(min_cy)
  );

  rtc_wrap_field #(.W(HOUR_W), .LAST(HOUR_LAST)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc_i(min_cy), .wr_i(wr_h),
    .wdata_i(wr_data[HOUR_W-1:0]), .val_o(hour_v), .carry_o(hour_cy)
  );

  assign day_wrap = hour_cy && (day_q == '1);

  always_comb begin
    day_nx = day_q + DAY_W'(hour_cy);
    if (wr_dl) day_nx[BYTE_W-1:0] = wr_data;
    if (wr_dh) day_nx[DAY_W-1]    = wr_data[CTL_DAY8];
    halt_nx = wr_dh ? wr_data[CTL_HALT] : halt_q;
    roll_nx = wr_dh ? wr_data[CTL_ROLL] : (roll_q || day_wrap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q  <= '0;
      halt_q <= 1'b0;
      roll_q <= 1'b0;
    end else begin
      day_q  <= day_nx;
      halt_q <= halt_nx;
      roll_q <= roll_nx;
    end
  end

  assign out_sec    = BYTE_W'(sec_v);
  assign out_min    = BYTE_W'(min_v);
  assign out_hour   = BYTE_W'(hour_v);
  assign out_day_lo = day_q[BYTE_W-1:0];
  assign out_day_hi = {roll_q, halt_q, 5'b0, day_q[DAY_W-1]};
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] out_sec,
  input logic [7:0] out_min,
  input logic [7:0] out_hour,
  input logic [7:0] out_day_lo,
  input logic [7:0] out_day_hi
);
  // R2: outside the roll points seconds either hold or step by one
  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && out_sec != 8'd59 && out_sec != 8'd63) |=>
      (out_sec == $past(out_sec) || out_sec == $past(out_sec) + 8'd1));

  // R3: minutes move only on a seconds carry
  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && out_sec != 8'd59) |=> $stable(out_min));

  // R4: the day number moves only on an hours carry
  p_day_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && out_hour != 8'd23) |=> ($stable(out_day_lo) && $stable(out_day_hi[0])));

  // R6: the rollover flag stays set without a control write
  p_roll_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_day_hi[7] && !(wr_en && wr_sel == 3'd4)) |=> out_day_hi[7]);

  // R7: halted time does not move
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_day_hi[6] && !wr_en) |=>
      ($stable(out_sec) && $stable(out_min) && $stable(out_hour) && $stable(out_day_lo)));

  // R10: a minutes write lands on the next cycle
  p_min_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd1) |=> out_min == {2'b00, $past(wr_data[5:0])});
endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (.*);

// File: tb/rtc_timekeeper_test.sv
`timescale 1ns/1ps
module rtc_timekeeper_test;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] out_sec, out_min, out_hour, out_day_lo, out_day_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_timekeeper #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour),
    .out_day_lo(out_day_lo), .out_day_hi(out_day_hi)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] dl, input logic [7:0] dh);
    wr(3'd0, 8'd0);
    wr(3'd3, dl);
    wr(3'd4, dh);
    wr(3'd2, h);
    wr(3'd1, m);
    wr(3'd0, s);
  endtask

  task automatic t_reset;
    idle(3);
    check("R1 sec", out_sec, 8'h00);
    check("R1 min", out_min, 8'h00);
    check("R1 hour", out_hour, 8'h00);
    check("R1 daylo", out_day_lo, 8'h00);
    check("R1 dayhi", out_day_hi, 8'h00);
    rst_n = 1'b1;
    idle(DIV - 1);
    check("R1 no step yet", out_sec, 8'h00);
    idle(1);
    check("R1 first step", out_sec, 8'h01);
  endtask

  task automatic t_tick;
    wr(3'd0, 8'd20);
    check("R10 sec readback", out_sec, 8'd20);
    idle(DIV - 1);
    check("R8 held before step", out_sec, 8'd20);
    idle(1);
    check("R8 step after write", out_sec, 8'd21);
    idle(3 * DIV);
    check("R2 steady rate", out_sec, 8'd24);
  endtask

  task automatic t_roll;
    set_time(8'd3, 8'd59, 8'd59, 8'd0, 8'd0);
    idle(DIV);
    check("R3 sec roll", out_sec, 8'd0);
    check("R3 min roll", out_min, 8'd0);
    check("R3 hour carry", out_hour, 8'd4);
    set_time(8'd7, 8'd10, 8'd59, 8'd0, 8'd0);
    idle(DIV);
    check("R3 min carry", out_min, 8'd11);
    check("R3 hour kept", out_hour, 8'd7);
  endtask

  task automatic t_day;
    set_time(8'd23, 8'd59, 8'd59, 8'hFF, 8'h00);
    idle(DIV);
    check("R4 hour roll", out_hour, 8'd0);
    check("R5 day low", out_day_lo, 8'h00);
    check("R5 day bit8", out_day_hi, 8'h01);
  endtask

  task automatic t_wrap;
    set_time(8'd23, 8'd59, 8'd59, 8'hFF, 8'h01);
    idle(DIV);
    check("R6 day low", out_day_lo, 8'h00);
    check("R6 flag set", out_day_hi, 8'h80);
    idle(DIV);
    check("R6 sticky", out_day_hi, 8'h80);
    check("R6 time runs", out_sec, 8'd1);
    wr(3'd4, 8'h00);
    check("R6 cleared", out_day_hi, 8'h00);
  endtask

  task automatic t_halt;
    wr(3'd0, 8'd10);
    wr(3'd4, 8'h40);
    check("R7 halt bit", out_day_hi, 8'h40);
    idle(40);
    check("R7 frozen", out_sec, 8'd10);
    wr(3'd1, 8'd7);
    check("R10 write while halted", out_min, 8'd7);
    idle(20);
    check("R7 still frozen", out_sec, 8'd10);
    wr(3'd4, 8'h00);
    idle(DIV - 2);
    check("R7 remainder pending", out_sec, 8'd10);
    idle(1);
    check("R7 resumes after remainder", out_sec, 8'd11);
  endtask

  task automatic t_range;
    set_time(8'd2, 8'd5, 8'd62, 8'h00, 8'h00);
    idle(DIV);
    check("R9 sec to 63", out_sec, 8'd63);
    idle(DIV);
    check("R9 sec wraps", out_sec, 8'd0);
    check("R9 no min carry", out_min, 8'd5);
    set_time(8'd30, 8'd59, 8'd59, 8'h05, 8'h00);
    idle(DIV);
    check("R9 hour to 31", out_hour, 8'd31);
    set_time(8'd31, 8'd59, 8'd59, 8'h05, 8'h00);
    idle(DIV);
    check("R9 hour wraps", out_hour, 8'd0);
    check("R9 no day carry", out_day_lo, 8'h05);
  endtask

  task automatic t_ignore;
    set_time(8'd9, 8'd8, 8'd7, 8'h42, 8'h00);
    wr(3'd5, 8'h3B);
    wr(3'd7, 8'hFF);
    check("R10 sel5-7 sec", out_sec, 8'd7);
    check("R10 sel5-7 min", out_min, 8'd8);
    check("R10 sel5-7 hour", out_hour, 8'd9);
    check("R10 sel5-7 daylo", out_day_lo, 8'h42);
    check("R10 sel5-7 dayhi", out_day_hi, 8'h00);
    wr(3'd4, 8'h3E);
    check("R10 ctl masked", out_day_hi, 8'h00);
    wr(3'd2, 8'hFF);
    check("R10 hour masked", out_hour, 8'h1F);
    wr(3'd0, 8'hFF);
    check("R10 sec masked", out_sec, 8'h3F);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_tick();
    t_roll();
    t_day();
    t_wrap();
    t_halt();
    t_range();
    t_ignore();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule